// File: doc/BRIEF.md
# Keyboard Row, Drive Select and Status Port Glue

This block sits behind a three-port parallel interface. A byte written to the control port is held in a register. Its fields pick one row of a ten-row keyboard matrix, pick one of two floppy drives and drive the printer strobe. The first read port returns the key columns of the chosen row. The second read port gathers printer busy, motor feedback and the write-protect state of the chosen drive.

A timer channel output switches the drive motor. That motor-on level is passed only to the drive that is currently selected, and its inverse appears as feedback on the status port. Two lines from the floppy controller are turned into CPU interrupts. The data request becomes a non-maskable interrupt, but only while the CPU is halted, so that bytes move in step with the halt instruction. The completion interrupt is passed on as the maskable interrupt level.

Top module: `kbd_drive_glue`

## Requirements
- R1: While and right after synchronous reset the control register is 0: no drive selected, row index 0, strobe low; NMI and IRQ are low.
- R2: A write to the control port takes effect on the clock edge that samples the write enable, and its fields are visible on the outputs from the next cycle.
- R3: For a row index 0 to 9 (control bits 3:0), the key port returns that row's 8 active-low column bits unchanged (row r occupies key_rows bits 8r+7 down to 8r) and follows changes on those inputs combinationally.
- R4: For a row index 10 to 15 the key port returns 0xFF.
- R5: Control bit 4 selects drive 0 (drv_sel = 01), bit 5 selects drive 1 (drv_sel = 10), neither gives 00, and with both set drive 1 wins.
- R6: The printer strobe output equals control bit 7.
- R7: The status port carries printer busy on bit 4, the inverse of motor-on on bit 5, and the selected drive's write-protect on bit 7 (0 with no drive selected); bits 0 to 3 and 6 read 0.
- R8: The motor-on level reaches only the selected drive's motor output; unselected drives see 0.
- R9: NMI rises in the cycle after data request and halt are both high, stays high while data request stays high even if halt drops, and clears the cycle after data request falls; a data request without halt leaves NMI low until halt arrives.
- R10: IRQ follows the controller interrupt line with one cycle of delay, both when set and when cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pa_we | input | 1 | Control port write enable |
| pa_wdata | input | 8 | Control port write data |
| key_rows | input | 80 | Ten keyboard rows, 8 active-low columns each |
| prn_busy | input | 1 | Printer busy |
| motor_on | input | 1 | Motor-on level from the timer channel |
| drv_wprot | input | 2 | Write-protect per drive, 1 = protected |
| fdc_drq | input | 1 | Floppy controller data request |
| fdc_intrq | input | 1 | Floppy controller completion interrupt |
| cpu_halt | input | 1 | CPU is in the halted state |
| pb_data | output | 8 | Key port read data |
| pc_data | output | 8 | Status port read data |
| drv_sel | output | 2 | One-hot drive select |
| drv_motor | output | 2 | Motor-on per drive |
| prn_strobe | output | 1 | Printer strobe |
| nmi | output | 1 | Non-maskable interrupt request |
| irq | output | 1 | Maskable interrupt request |

## Verification
The bench walks all sixteen row indices, so a decoder that wraps or lets indices 10 to 15 alias onto real rows returns key data where 0xFF is due. It writes both drive bits together, and a design that favoured drive 0 would show the wrong select, motor and write-protect bit. For NMI it raises data request before halt, which catches a design that latches only on the request's rising edge and never fires. It then drops halt with the request still high, which catches a design that clears NMI with halt rather than with the request.

// File: rtl/kbd_glue_pkg.sv
package kbd_glue_pkg;

    localparam int ROW_FIELD_W = 4;
    localparam int NUM_DRIVES  = 2;
    localparam int PORT_W      = 8;

    // status port bit positions
    localparam int ST_BUSY_BIT = 4;
    localparam int ST_MFB_BIT  = 5;
    localparam int ST_WP_BIT   = 7;

    typedef struct packed {
        logic                   strobe;   // bit 7
        logic                   spare;    // bit 6
        logic                   drv1;     // bit 5
        logic                   drv0;     // bit 4
        logic [ROW_FIELD_W-1:0] row;      // bits 3:0
    } ctrl_t;

    // drive 1 wins when both bits are set
    function automatic logic [NUM_DRIVES-1:0] pick_drive(input ctrl_t c);
        logic [NUM_DRIVES-1:0] s;
        s = '0;
        if (c.drv1)      s[1] = 1'b1;
        else if (c.drv0) s[0] = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/glue_ctrl_reg.sv
module glue_ctrl_reg
    import kbd_glue_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PORT_W-1:0] wdata,
    output ctrl_t             q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= ctrl_t'(wdata);
    end
endmodule

// File: rtl/glue_row_mux.sv
module glue_row_mux #(
    parameter int NUM_ROWS = 10,
    parameter int COLS     = 8,
    parameter int IDX_W    = 4
) (
    input  logic [NUM_ROWS*COLS-1:0] rows,
    input  logic [IDX_W-1:0]         idx,
    output logic [COLS-1:0]          cols
);
    always_comb begin
        cols = '1;
        for (int i = 0; i < NUM_ROWS; i++) begin
            if (idx == IDX_W'(i)) cols = rows[i*COLS +: COLS];
        end
    end
endmodule

// File: rtl/glue_status.sv
module glue_status
    import kbd_glue_pkg::*;
(
    input  logic                  busy,
    input  logic                  motor_on,
    input  logic [NUM_DRIVES-1:0] wprot,
    input  logic [NUM_DRIVES-1:0] sel,
    output logic [PORT_W-1:0]     status,
    output logic [NUM_DRIVES-1:0] motor
);
    always_comb begin
        status              = '0;
        status[ST_BUSY_BIT] = busy;
        status[ST_MFB_BIT]  = ~motor_on;
        status[ST_WP_BIT]   = |(wprot & sel);
    end

    genvar d;
    generate
        for (d = 0; d < NUM_DRIVES; d++) begin : g_motor
            assign motor[d] = sel[d] & motor_on;
        end
    endgenerate
endmodule

// File: rtl/glue_irq.sv
module glue_irq (
    input  logic clk,
    input  logic rst,
    input  logic drq,
    input  logic halt,
    input  logic intrq,
    output logic nmi,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            nmi <= 1'b0;
            irq <= 1'b0;
        end else begin
            nmi <= drq & (nmi | halt);
            irq <= intrq;
        end
    end
endmodule

// File: rtl/kbd_drive_glue.sv
module kbd_drive_glue
    import kbd_glue_pkg::*;
#(
    parameter int NUM_ROWS = 10,
    parameter int KEY_COLS = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pa_we,
    input  logic [7:0]                   pa_wdata,
    input  logic [NUM_ROWS*KEY_COLS-1:0] key_rows,
    input  logic                         prn_busy,
    input  logic                         motor_on,
    input  logic [1:0]                   drv_wprot,
    input  logic                         fdc_drq,
    input  logic                         fdc_intrq,
    input  logic                         cpu_halt,
    output logic [KEY_COLS-1:0]          pb_data,
    output logic [7:0]                   pc_data,
    output logic [1:0]                   drv_sel,
    output logic [1:0]                   drv_motor,
    output logic                         prn_strobe,
    output logic                         nmi,
    output logic                         irq
);
    localparam int ROW_IDX_W = ROW_FIELD_W;

    ctrl_t pa_q;
    logic  unused_spare;

    glue_ctrl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (pa_we),
        .wdata (pa_wdata),
        .q     (pa_q)
    );

    assign unused_spare = pa_q.spare;
    assign drv_sel      = pick_drive(pa_q);
    assign prn_strobe   = pa_q.strobe;

    glue_row_mux #(
        .NUM_ROWS (NUM_ROWS),
        .COLS     (KEY_COLS),
        .IDX_W    (ROW_IDX_W)
    ) u_rows (
        .rows (key_rows),
        .idx  (pa_q.row),
        .cols (pb_data)
    );

    glue_status u_stat (
        .busy     (prn_busy),
        .motor_on (motor_on),
        .wprot    (drv_wprot),
        .sel      (drv_sel),
        .status   (pc_data),
        .motor    (drv_motor)
    );

    glue_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .drq   (fdc_drq),
        .halt  (cpu_halt),
        .intrq (fdc_intrq),
        .nmi   (nmi),
        .irq   (irq)
    );
endmodule

// File: rtl/kbd_drive_glue_chk.sv
module kbd_drive_glue_chk #(
    parameter int NUM_ROWS = 10
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] pa_bits,
    input logic [7:0] pb_data,
    input logic [7:0] pc_data,
    input logic [1:0] drv_sel,
    input logic [1:0] drv_motor,
    input logic       prn_strobe,
    input logic       motor_on,
    input logic       fdc_drq,
    input logic       fdc_intrq,
    input logic       cpu_halt,
    input logic       nmi,
    input logic       irq
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (drv_sel == 2'b00 && !prn_strobe && !nmi && !irq));

    // R4
    oob_row_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(pa_bits[3:0]) >= NUM_ROWS) |-> (pb_data == 8'hFF));

    // R5
    drv_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv_sel));

    // R7
    pc_spare_chk: assert property (@(posedge clk) disable iff (rst)
        ((pc_data & 8'h4F) == 8'h00) && (pc_data[5] != motor_on));

    // R8
    motor_sel_chk: assert property (@(posedge clk) disable iff (rst)
        ((drv_motor & ~drv_sel) == 2'b00));

    // R9
    nmi_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (fdc_drq && cpu_halt) |=> nmi);

    // R9
    nmi_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !fdc_drq |=> !nmi);

    // R9
    nmi_nohalt_chk: assert property (@(posedge clk) disable iff (rst)
        (fdc_drq && !cpu_halt && !nmi) |=> !nmi);

    // R10
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        fdc_intrq |=> irq);

    // R10
    irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
        !fdc_intrq |=> !irq);
endmodule

bind kbd_drive_glue kbd_drive_glue_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pa_bits    (pa_q),
    .pb_data    (pb_data),
    .pc_data    (pc_data),
    .drv_sel    (drv_sel),
    .drv_motor  (drv_motor),
    .prn_strobe (prn_strobe),
    .motor_on   (motor_on),
    .fdc_drq    (fdc_drq),
    .fdc_intrq  (fdc_intrq),
    .cpu_halt   (cpu_halt),
    .nmi        (nmi),
    .irq        (irq)
);

// File: tb/kbd_drive_glue_bench.sv
`timescale 1ns/1ps
module kbd_drive_glue_bench;

    typedef enum int {K_PB, K_PC, K_SEL, K_STB, K_NMI, K_IRQ, K_MOT} kind_t;
    typedef struct {
        string      req;
        kind_t      kind;
        logic [7:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pa_we = 1'b0;
    logic [7:0]  pa_wdata = '0;
    logic [79:0] key_rows = '1;
    logic        prn_busy = 1'b0;
    logic        motor_on = 1'b0;
    logic [1:0]  drv_wprot = '0;
    logic        fdc_drq = 1'b0;
    logic        fdc_intrq = 1'b0;
    logic        cpu_halt = 1'b0;
    logic [7:0]  pb_data, pc_data;
    logic [1:0]  drv_sel, drv_motor;
    logic        prn_strobe, nmi, irq;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #2.5 clk = ~clk;

    kbd_drive_glue u_kbd_drive_glue (
        .clk(clk), .rst(rst), .pa_we(pa_we), .pa_wdata(pa_wdata),
        .key_rows(key_rows), .prn_busy(prn_busy), .motor_on(motor_on),
        .drv_wprot(drv_wprot), .fdc_drq(fdc_drq), .fdc_intrq(fdc_intrq),
        .cpu_halt(cpu_halt), .pb_data(pb_data), .pc_data(pc_data),
        .drv_sel(drv_sel), .drv_motor(drv_motor), .prn_strobe(prn_strobe),
        .nmi(nmi), .irq(irq)
    );

    function automatic logic [7:0] row_val(input int r);
        return 8'((r * 37 + 5) ^ 8'hA5);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_v(input string req, input kind_t k, input logic [7:0] e);
        item_t it;
        it.req = req; it.kind = k; it.exp = e;
        q.push_back(it);
    endtask

    task automatic wr_pa(input logic [7:0] d);
        pa_we = 1'b1; pa_wdata = d;
        tick();
        pa_we = 1'b0;
    endtask

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.kind)
                K_PB:    act = pb_data;
                K_PC:    act = pc_data;
                K_SEL:   act = {6'b0, drv_sel};
                K_STB:   act = {7'b0, prn_strobe};
                K_NMI:   act = {7'b0, nmi};
                K_IRQ:   act = {7'b0, irq};
                default: act = {6'b0, drv_motor};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 10; r++) key_rows[r*8 +: 8] = row_val(r);
        tick(); tick();
        // R1: state held during reset
        expect_v("R1", K_SEL, 8'h00);
        expect_v("R1", K_STB, 8'h00);
        tick();
        rst = 1'b0;
        tick();
        // R1: after reset, row 0 selected, nothing else active
        expect_v("R1", K_SEL, 8'h00);
        expect_v("R1", K_STB, 8'h00);
        expect_v("R1", K_PB, row_val(0));
        expect_v("R1", K_NMI, 8'h00);
        expect_v("R1", K_IRQ, 8'h00);
        tick();

        // R2 R3 R4: sweep every row index
        for (int r = 0; r < 16; r++) begin
            wr_pa(8'(r));
            if (r <= 9) expect_v("R3", K_PB, row_val(r));
            else        expect_v("R4", K_PB, 8'hFF);
            tick();
        end
        // R2: no write enable, no change
        pa_wdata = 8'h03;
        tick();
        expect_v("R2", K_PB, 8'hFF);
        tick();
        // R3: combinational follow of key inputs
        wr_pa(8'h07);
        key_rows[7*8 +: 8] = 8'h5A;
        expect_v("R3", K_PB, 8'h5A);
        tick();

        // R5 drive selection and priority
        wr_pa(8'h10); expect_v("R5", K_SEL, 8'h01); tick();
        wr_pa(8'h20); expect_v("R5", K_SEL, 8'h02); tick();
        wr_pa(8'h30); expect_v("R5", K_SEL, 8'h02); tick();
        wr_pa(8'h00); expect_v("R5", K_SEL, 8'h00); tick();
        // R6 strobe
        wr_pa(8'h80); expect_v("R6", K_STB, 8'h01); tick();
        wr_pa(8'h00); expect_v("R6", K_STB, 8'h00); tick();

        // R7 status port
        prn_busy = 1'b1; motor_on = 1'b1; drv_wprot = 2'b10;
        wr_pa(8'h10); expect_v("R7", K_PC, 8'h10); tick();
        wr_pa(8'h20); expect_v("R7", K_PC, 8'h90); tick();
        wr_pa(8'h30); expect_v("R7", K_PC, 8'h90); tick();
        motor_on = 1'b0;
        tick(); expect_v("R7", K_PC, 8'hB0); tick();
        wr_pa(8'h00); expect_v("R7", K_PC, 8'h30); tick();
        prn_busy = 1'b0;
        tick(); expect_v("R7", K_PC, 8'h20); tick();

        // R8 motor routing
        motor_on = 1'b1;
        wr_pa(8'h20); expect_v("R8", K_MOT, 8'h02); tick();
        wr_pa(8'h10); expect_v("R8", K_MOT, 8'h01); tick();
        wr_pa(8'h00); expect_v("R8", K_MOT, 8'h00); tick();
        motor_on = 1'b0;
        wr_pa(8'h10); expect_v("R8", K_MOT, 8'h00); tick();

        // R9 halt-gated NMI
        fdc_drq = 1'b1;
        tick(); expect_v("R9", K_NMI, 8'h00);
        tick(); expect_v("R9", K_NMI, 8'h00);
        cpu_halt = 1'b1;
        tick(); expect_v("R9", K_NMI, 8'h01);
        cpu_halt = 1'b0;
        tick(); expect_v("R9", K_NMI, 8'h01);
        fdc_drq = 1'b0;
        tick(); expect_v("R9", K_NMI, 8'h00);
        cpu_halt = 1'b1;
        tick(); expect_v("R9", K_NMI, 8'h00);
        fdc_drq = 1'b1;
        tick(); expect_v("R9", K_NMI, 8'h01);
        fdc_drq = 1'b0; cpu_halt = 1'b0;
        tick(); expect_v("R9", K_NMI, 8'h00);

        // R10 IRQ level with one cycle delay
        fdc_intrq = 1'b1;
        expect_v("R10", K_IRQ, 8'h00);
        tick(); expect_v("R10", K_IRQ, 8'h01);
        tick(); expect_v("R10", K_IRQ, 8'h01);
        fdc_intrq = 1'b0;
        tick(); expect_v("R10", K_IRQ, 8'h00);
        tick(); tick();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule